// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked host read and write single bytes in an external asynchronous static RAM (32K x 8 by default). The host presents a request with a valid/ready handshake: an address, a write flag and write data. For a read, the block returns the byte on a response bus qualified by a one-cycle valid strobe. On the memory side it drives the address, three active-low strobes (chip select, output enable, write strobe) and a data bus split into an outgoing value, an incoming value and a driver enable for the pad.

The memory has no clock, so every interval it needs is produced by counting clock cycles. Each minimum (read access, output-enable access, write pulse, data setup, bus turnaround) is a parameter in cycles. Writes are terminated by the write strobe while output enable stays high, so the memory never drives the bus during a write. A write that follows a read waits a programmable number of idle cycles after output enable has risen before the block turns on its own drivers. Every memory-side output comes straight from a flop, so no strobe can glitch.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, chip select, output enable and the write strobe are all high, the data driver enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: `req_ready` is high only when no access is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the cycle after the access ends.
- R3: A read lowers chip select with the address in the first cycle after it is accepted. Output enable goes low one cycle later and stays low for exactly max(T_RC, T_OE_ACC) cycles. `rsp_valid` is high in the cycle directly after that, which is 2 + max(T_RC, T_OE_ACC) cycles after the accept edge. In that cycle chip select and output enable are already high.
- R4: A write spends one cycle with chip select low, the write strobe high and the data driver on. It then holds the write strobe low for exactly max(T_WP, T_DW) cycles. It then spends one recovery cycle with the write strobe high, chip select low and the driver still on. `req_ready` returns in the cycle after recovery.
- R5: The write strobe is low only while chip select is low. It falls only when chip select was already low in the previous cycle. Chip select never rises while the write strobe is low.
- R6: The data driver enable is high only while output enable is high, so the controller and the memory never drive the data bus at the same time.
- R7: A write accepted after a read turns its driver on 1 + T_TURN cycles after its accept edge. Any other write turns its driver on 1 cycle after its accept edge.
- R8: The address, and for writes the outgoing data, stay constant for as long as chip select is continuously low.
- R9: Each read produces exactly one `rsp_valid` cycle. `rsp_rdata` holds the byte the memory presents on the incoming bus in the last cycle that output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle strobe qualifying read data |
| rsp_rdata | output | DATA_W | Byte returned by a read |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_in | input | DATA_W | Data from the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |

## Verification
A wrong state in the sequencer shows at the memory pins within one cycle, because every strobe is a flop loaded from the next state. A skipped or repeated phase changes how many cycles output enable or the write strobe stays low. A missed turnaround moves the first driver-enable cycle relative to the accept edge. A wrong capture point returns a byte that differs from the reference array on the next read of that address. The memory model also counts three kinds of protocol fault: a write strobe low without chip select, chip select releasing before the write strobe, and both sides driving the bus at once. Any of these makes the final counters non-zero even when the data happens to match.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_WAIT,
        ST_RD_CAPTURE,
        ST_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } ctrl_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
`timescale 1ns/1ps
// Down-counter for phase lengths: a load of N makes done high in the N-th cycle after the load edge.
module sram_phase_cnt #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
// Holds the byte sampled from the memory at the end of the output-enable window.
module sram_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = cap_en ? din : data_q;
    end

    always_ff @(posedge clk) begin
        if (rst) data_q <= '0;
        else     data_q <= data_d;
    end

    assign dout = data_q;
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned T_RC     = 2,
    parameter int unsigned T_WP     = 1,
    parameter int unsigned T_DW     = 1,
    parameter int unsigned T_OE_ACC = 1,
    parameter int unsigned T_TURN   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int unsigned RD_LEN  = max2(T_RC, T_OE_ACC);
    localparam int unsigned WP_LEN  = max2(T_WP, T_DW);
    localparam int unsigned CNT_MAX = max2(max2(RD_LEN, WP_LEN), T_TURN);
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        ctrl_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic              rsp_v;
        logic              rd_last;
    } regs_t;

    regs_t             r_d, r_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              cap_en;

    sram_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_en),
        .din    (mem_dq_in),
        .dout   (rsp_rdata)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rsp_v = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        cap_en    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    if (!req_we) begin
                        r_d.st = ST_RD_SETUP;
                    end else if (r_q.rd_last) begin
                        r_d.st   = ST_TURN;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(T_TURN);
                    end else begin
                        r_d.st = ST_WR_SETUP;
                    end
                end
            end
            ST_RD_SETUP: begin
                r_d.st   = ST_RD_WAIT;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RD_LEN);
            end
            ST_RD_WAIT: begin
                if (tmr_done) begin
                    cap_en      = 1'b1;
                    r_d.st      = ST_RD_CAPTURE;
                    r_d.rsp_v   = 1'b1;
                    r_d.rd_last = 1'b1;
                end
            end
            ST_RD_CAPTURE: r_d.st = ST_IDLE;
            ST_TURN: begin
                if (tmr_done) r_d.st = ST_WR_SETUP;
            end
            ST_WR_SETUP: begin
                r_d.st      = ST_WR_PULSE;
                r_d.rd_last = 1'b0;
                tmr_load    = 1'b1;
                tmr_val     = CNT_W'(WP_LEN);
            end
            ST_WR_PULSE: begin
                if (tmr_done) r_d.st = ST_WR_RECOVER;
            end
            ST_WR_RECOVER: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
        // Memory-side strobes follow the state being entered, so each pin is a flop.
        r_d.ce_n  = !(r_d.st inside {ST_RD_SETUP, ST_RD_WAIT,
                                     ST_WR_SETUP, ST_WR_PULSE, ST_WR_RECOVER});
        r_d.oe_n  = (r_d.st != ST_RD_WAIT);
        r_d.we_n  = (r_d.st != ST_WR_PULSE);
        r_d.dq_oe = (r_d.st inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_RECOVER});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
            r_q.ce_n    <= 1'b1;
            r_q.oe_n    <= 1'b1;
            r_q.we_n    <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign rsp_valid  = r_q.rsp_v;
    assign mem_addr   = r_q.addr;
    assign mem_ce_n   = r_q.ce_n;
    assign mem_oe_n   = r_q.oe_n;
    assign mem_we_n   = r_q.we_n;
    assign mem_dq_out = r_q.wdata;
    assign mem_dq_oe  = r_q.dq_oe;

    // R1: strobes inactive and drivers released after a reset cycle
    p_reset_safe_r1: assert property (@(posedge clk)
        rst |=> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid));

    // R2: an idle controller leaves the memory deselected and undriven
    p_ready_idle_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && !mem_dq_oe));

    // R3: output enable falls only after chip select has been low for a cycle
    p_oe_after_ce_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> ($past(!mem_ce_n) && !mem_ce_n));

    // R4: write strobe rises into a recovery cycle with select and drivers held
    p_recover_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe));

    // R5: write strobe only inside the chip-select window
    p_we_in_ce_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_ce_n);

    // R5: chip select leads the write strobe
    p_ce_leads_we_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> $past(!mem_ce_n));

    // R6: never drive while the memory outputs are enabled
    p_no_contention_r6: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    // R7: drivers turn on only after output enable was high the cycle before
    p_turn_gap_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));

    // R8: address and outgoing data stable across a select window
    p_addr_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    // R9: response strobe lasts a single cycle
    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;
    localparam int AW       = 8;
    localparam int DW       = 8;
    localparam int T_RC     = 2;
    localparam int T_WP     = 1;
    localparam int T_DW     = 1;
    localparam int T_OE_ACC = 1;
    localparam int T_TURN   = 1;
    localparam int RD_LEN   = (T_RC > T_OE_ACC) ? T_RC : T_OE_ACC;
    localparam int WP_LEN   = (T_WP > T_DW) ? T_WP : T_DW;
    localparam int DEPTH    = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    always #2.5 clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .T_RC(T_RC), .T_WP(T_WP),
        .T_DW(T_DW), .T_OE_ACC(T_OE_ACC), .T_TURN(T_TURN)
    ) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    // Behavioural memory and fault counters
    logic [DW-1:0] mem_arr [DEPTH];
    logic [DW-1:0] ref_arr [DEPTH];
    int  n_overlap_bad = 0;
    int  n_order_bad   = 0;
    int  n_contend     = 0;
    int  n_undriven_wr = 0;
    wire mem_drives = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq_in = mem_drives ? mem_arr[mem_addr] : '0;

    always @(posedge mem_we_n) begin
        if (mem_ce_n === 1'b0) begin
            if (mem_dq_oe !== 1'b1) n_undriven_wr++;
            mem_arr[mem_addr] = mem_dq_out;
        end
    end
    always @(posedge mem_ce_n) begin
        if (!rst && mem_we_n === 1'b0) n_order_bad++;
    end
    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_we_n && mem_ce_n) n_overlap_bad++;
            if (mem_drives && mem_dq_oe) n_contend++;
        end
    end

    int n_chk  = 0;
    int n_fail = 0;
    bit last_rd = 1'b0;

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic op_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int first_oe = 0, first_we = 0, n_we = 0, idx_rdy = 0, bad_val = 0;
        int exp_first = last_rd ? 1 + T_TURN : 1;
        issue(1'b1, a, d);
        for (int idx = 1; idx < 60; idx++) begin
            @(negedge clk);
            if (idx == 1) req_valid = 1'b0;
            if (mem_dq_oe && first_oe == 0) first_oe = idx;
            if (!mem_we_n) begin
                n_we++;
                if (first_we == 0) first_we = idx;
                if (mem_addr != a || mem_dq_out != d) bad_val++;
            end
            if (req_ready) begin idx_rdy = idx; break; end
        end
        chk_eq("R7 driver-on cycle after accept", first_oe, exp_first);
        chk_eq("R4 strobe falls after setup cycle", first_we, exp_first + 1);
        chk_eq("R4 write strobe low cycles", n_we, WP_LEN);
        chk_eq("R2 ready return after write", idx_rdy, exp_first + WP_LEN + 2);
        chk_eq("R8 addr/data during strobe", bad_val, 0);
        ref_arr[a] = d;
        last_rd = 1'b0;
    endtask

    task automatic op_read(input logic [AW-1:0] a);
        int first_oe = 0, n_oe = 0, idx_rsp = 0, n_rsp = 0, idx_rdy = 0, bad_addr = 0;
        int first_ce = 0, got = 0;
        issue(1'b0, a, '0);
        for (int idx = 1; idx < 60; idx++) begin
            @(negedge clk);
            if (idx == 1) req_valid = 1'b0;
            if (!mem_ce_n) begin
                if (first_ce == 0) first_ce = idx;
                if (mem_addr != a) bad_addr++;
            end
            if (!mem_oe_n) begin
                n_oe++;
                if (first_oe == 0) first_oe = idx;
            end
            if (rsp_valid) begin
                n_rsp++; idx_rsp = idx; got = int'(rsp_rdata);
                chk_eq("R3 strobes released at response", int'({mem_ce_n, mem_oe_n}), 3);
            end
            if (req_ready) begin idx_rdy = idx; break; end
        end
        chk_eq("R3 select cycle", first_ce, 1);
        chk_eq("R3 output-enable first cycle", first_oe, 2);
        chk_eq("R3 output-enable low cycles", n_oe, RD_LEN);
        chk_eq("R3 response cycle", idx_rsp, 2 + RD_LEN);
        chk_eq("R9 single response", n_rsp, 1);
        chk_eq("R9 read data", got, int'(ref_arr[a]));
        chk_eq("R2 ready return after read", idx_rdy, 3 + RD_LEN);
        chk_eq("R8 address during read", bad_addr, 0);
        last_rd = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_arr[i] = '0;
            ref_arr[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_eq("R1 strobes in reset", int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
        chk_eq("R1 driver in reset", int'(mem_dq_oe), 0);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1 strobes after reset", int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
        chk_eq("R1 ready after reset", int'(req_ready), 1);
        chk_eq("R1 no response after reset", int'(rsp_valid), 0);

        // Full sweep: write every address, then read every address back
        for (int a = 0; a < DEPTH; a++)
            op_write(AW'(a), DW'((a * 7 + 3) ^ 8'h5A));
        for (int a = 0; a < DEPTH; a++)
            op_read(AW'(a));

        // Read immediately followed by a write and a read of the same location (R7)
        op_read(AW'(17));
        op_write(AW'(17), 8'hC3);
        op_read(AW'(17));
        op_write(AW'(DEPTH - 1), 8'hFF);
        op_write(AW'(0), 8'h00);
        op_read(AW'(DEPTH - 1));
        op_read(AW'(0));

        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            a = AW'($urandom % DEPTH);
            if ($urandom % 2 == 0) op_write(a, DW'($urandom));
            else                   op_read(a);
        end

        repeat (4) @(negedge clk);
        chk_eq("R5 strobe outside select", n_overlap_bad, 0);
        chk_eq("R5 select released before strobe", n_order_bad, 0);
        chk_eq("R6 bus contention cycles", n_contend, 0);
        chk_eq("R4 write latched without drivers", n_undriven_wr, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule